// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a single transmit descriptor ring in memory. Software sets the ring's start address and size through a small register port and sets a run bit. It then moves a tail index forward to give descriptors to the engine. For each descriptor it owns, the engine reads four 32-bit words over a request/acknowledge memory read port. It joins them into one 128-bit descriptor and offers that descriptor on a valid/ready stream. It steps to the next ring slot only after the consumer accepts the descriptor.

Ownership follows from the positions of the current index and the tail index, not from a flag in each descriptor. Slots from the current index up to, but not including, the tail belong to the engine. When the current index catches up with the tail, the engine parks in a suspended state and raises a one-cycle interrupt. A later tail write that moves the tail away from the current index wakes it. After the last slot the index returns to slot zero at the start address. Clearing the run bit stops the engine and rewinds it to slot zero.

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset the engine is stopped. mem_req, desc_valid and susp_irq are low, and every register reads zero.
- R2: Register map for both read and write: 0 = control (bit 0 is run), 1 = start address (bits 3:0 read as zero), 2 = ring size minus one, 3 = tail index. Address 4 is the current descriptor address and is read-only, so a write to it has no effect. Address 5 is status. Unused addresses read zero. A write takes effect on the next cycle.
- R3: To fetch the descriptor at slot i, the engine reads the words at A, A+4, A+8 and A+12 in that order, where A = start + 16*i. Each word is taken in a cycle where mem_req and mem_ack are both high. mem_req and mem_addr stay unchanged while the acknowledge is missing.
- R4: After the fourth word, desc_valid is high and desc_word holds word 0 in bits 31:0 up to word 3 in bits 127:96. desc_addr is A. The descriptor stays unchanged until desc_ready is high, and the slot advances only on that accept.
- R5: The engine suspends when the slot index after an accept equals the tail. It also suspends when the run bit is found set while the current index already equals the tail.
- R6: The slot after index "ring size minus one" is slot 0, at the start address.
- R7: From suspended, a tail write that makes the tail differ from the current index starts a fetch on the next cycle.
- R8: A tail write in the same cycle as an accept is compared with the new tail value. If the new tail differs from the next index, the engine fetches and does not suspend.
- R9: With run clear, the engine goes to STOPPED on the next cycle from any state and the current index returns to 0. A tail write while stopped only updates the tail register.
- R10: susp_irq is high for exactly the first cycle in which the status reads SUSPENDED after entry from another state.
- R11: Status bits 1:0 give the state: 0 STOPPED, 1 FETCH, 2 PRESENT, 3 SUSPENDED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Read accepted; mem_rdata valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer accepts descriptor |
| desc_word | output | 128 | Assembled descriptor |
| desc_addr | output | 32 | Address of presented descriptor |
| susp_irq | output | 1 | One-cycle pulse on entry to SUSPENDED |

## Verification
An engine with the wrong slot index or word counter shows it at once: the next mem_addr is off, in the cycle after the bad update. A bad state shows on mem_req and desc_valid, and in the status read, during the same cycle. A wrong wrap or tail comparison shows as a fetch that should not happen, or a missing one, within one cycle of the accept that decided it. A bench model of the ring is compared with every output on every clock, so each of these faults is reported at the first cycle where it appears.

// File: rtl/desc_ring_pkg.sv
// Shared types and constants for the descriptor ring fetcher.
// Assumes a 32-bit register port and descriptors of four 32-bit words.
package desc_ring_pkg;
    localparam int DESC_WORDS = 4;
    localparam int REG_AW     = 3;

    localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] RA_START  = 3'd1;
    localparam logic [REG_AW-1:0] RA_SIZE   = 3'd2;
    localparam logic [REG_AW-1:0] RA_TAIL   = 3'd3;
    localparam logic [REG_AW-1:0] RA_CUR    = 3'd4;
    localparam logic [REG_AW-1:0] RA_STATUS = 3'd5;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PRES  = 2'd2,
        ST_SUSP  = 2'd3
    } ring_state_e;
endpackage

// File: rtl/ring_regs.sv
// Register file of the ring fetcher: run bit, start address, ring size, tail.
// Also presents the tail value as it stands this cycle, with a same-cycle
// write forwarded, so that the controller never acts on a stale tail.
// Assumes W >= IDX_W + 4.
module ring_regs
    import desc_ring_pkg::*;
#(
    parameter int W     = 32,
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [REG_AW-1:0] raddr,
    input  logic [IDX_W-1:0]  cur_idx,
    input  ring_state_e       state,
    output logic              run,
    output logic [W-1:0]      start_addr,
    output logic [IDX_W-1:0]  last_idx,
    output logic [IDX_W-1:0]  tail_now,
    output logic [W-1:0]      rdata
);
    localparam int PAD = W - IDX_W - 4;

    logic [IDX_W-1:0] tail_q;
    logic [W-1:0]     cur_addr;

    // Register writes; address 4 and status are read-only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run        <= 1'b0;
            start_addr <= '0;
            last_idx   <= '0;
            tail_q     <= '0;
        end else if (we) begin
            case (waddr)
                RA_CTRL:  run        <= wdata[0];
                RA_START: start_addr <= {wdata[W-1:4], 4'b0000};
                RA_SIZE:  last_idx   <= wdata[IDX_W-1:0];
                RA_TAIL:  tail_q     <= wdata[IDX_W-1:0];
                default:  ;
            endcase
        end
    end

    // Forward a tail write landing in the current cycle
    always_comb begin
        tail_now = (we && waddr == RA_TAIL) ? wdata[IDX_W-1:0] : tail_q;
    end

    // Byte address of the current slot
    always_comb begin
        cur_addr = start_addr + {{PAD{1'b0}}, cur_idx, 4'b0000};
    end

    // Read multiplexer
    always_comb begin
        case (raddr)
            RA_CTRL:   rdata = {{(W-1){1'b0}}, run};
            RA_START:  rdata = start_addr;
            RA_SIZE:   rdata = {{(W-IDX_W){1'b0}}, last_idx};
            RA_TAIL:   rdata = {{(W-IDX_W){1'b0}}, tail_q};
            RA_CUR:    rdata = cur_addr;
            RA_STATUS: rdata = {{(W-2){1'b0}}, state};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/ring_fetch_ctrl.sv
// Ring walker state machine: holds the current slot index and the word
// counter, issues memory reads, presents the descriptor, wraps after the
// last slot and suspends when the index meets the tail.
// Assumes the memory returns data in the same cycle as mem_ack.
module ring_fetch_ctrl
    import desc_ring_pkg::*;
#(
    parameter int W     = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [W-1:0]     start_addr,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] tail_now,
    input  logic             mem_ack,
    input  logic             desc_ready,
    output ring_state_e      state,
    output logic [IDX_W-1:0] cur_idx,
    output logic [$clog2(DESC_WORDS)-1:0] word_sel,
    output logic             cap_en,
    output logic             mem_req,
    output logic [W-1:0]     mem_addr,
    output logic             desc_valid,
    output logic [W-1:0]     desc_addr,
    output logic             susp_irq
);
    localparam int SEL_W = $clog2(DESC_WORDS);
    localparam int PAD   = W - IDX_W - 4;
    localparam logic [SEL_W-1:0] LAST_WORD = SEL_W'(DESC_WORDS - 1);

    ring_state_e      state_d;
    logic [IDX_W-1:0] idx_d, idx_inc;
    logic [SEL_W-1:0] sel_d;
    logic             irq_d;

    // Slot following the current one, wrapping after the last slot
    always_comb begin
        idx_inc = (cur_idx == last_idx) ? '0 : cur_idx + 1'b1;
    end

    // Next-state, index and word counter decisions
    always_comb begin
        state_d = state;
        idx_d   = cur_idx;
        sel_d   = word_sel;
        if (!run) begin
            state_d = ST_STOP;
            idx_d   = '0;
            sel_d   = '0;
        end else begin
            case (state)
                ST_STOP: begin
                    sel_d   = '0;
                    state_d = (tail_now != cur_idx) ? ST_FETCH : ST_SUSP;
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        sel_d = word_sel + 1'b1;
                        if (word_sel == LAST_WORD) state_d = ST_PRES;
                    end
                end
                ST_PRES: begin
                    if (desc_ready) begin
                        idx_d   = idx_inc;
                        state_d = (tail_now != idx_inc) ? ST_FETCH : ST_SUSP;
                    end
                end
                default: begin
                    if (tail_now != cur_idx) state_d = ST_FETCH;
                end
            endcase
        end
        irq_d = run && (state_d == ST_SUSP) && (state != ST_SUSP);
    end

    // State, index, word counter and interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_STOP;
            cur_idx  <= '0;
            word_sel <= '0;
            susp_irq <= 1'b0;
        end else begin
            state    <= state_d;
            cur_idx  <= idx_d;
            word_sel <= sel_d;
            susp_irq <= irq_d;
        end
    end

    // Memory and stream outputs
    always_comb begin
        mem_req    = (state == ST_FETCH);
        cap_en     = mem_req && mem_ack;
        desc_valid = (state == ST_PRES);
        desc_addr  = start_addr + {{PAD{1'b0}}, cur_idx, 4'b0000};
        mem_addr   = start_addr + {{PAD{1'b0}}, cur_idx, word_sel, 2'b00};
    end
endmodule

// File: rtl/ring_desc_asm.sv
// Collects the words of one descriptor into a wide register, one slot
// per word, written when the controller flags an accepted read.
module ring_desc_asm
    import desc_ring_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap_en,
    input  logic [$clog2(DESC_WORDS)-1:0] word_sel,
    input  logic [W-1:0]                  rdata,
    output logic [DESC_WORDS*W-1:0]       desc_word
);
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        logic [W-1:0] word_q;
        // Capture word g of the descriptor
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else if (cap_en && word_sel == g) word_q <= rdata;
        end
        assign desc_word[g*W +: W] = word_q;
    end
endmodule

// File: rtl/desc_ring_fetch.sv
// Top of the transmit descriptor ring fetcher: register file, walker state
// machine and descriptor assembly. Ownership is decided by comparing the
// current slot index with the software tail index.
module desc_ring_fetch
    import desc_ring_pkg::*;
#(
    parameter int W     = 32,
    parameter int IDX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [2:0]               reg_waddr,
    input  logic [W-1:0]             reg_wdata,
    input  logic [2:0]               reg_raddr,
    output logic [W-1:0]             reg_rdata,
    output logic                     mem_req,
    output logic [W-1:0]             mem_addr,
    input  logic                     mem_ack,
    input  logic [W-1:0]             mem_rdata,
    output logic                     desc_valid,
    input  logic                     desc_ready,
    output logic [DESC_WORDS*W-1:0]  desc_word,
    output logic [W-1:0]             desc_addr,
    output logic                     susp_irq
);
    localparam int SEL_W = $clog2(DESC_WORDS);

    logic             run_w;
    logic [W-1:0]     start_w;
    logic [IDX_W-1:0] last_w, tail_w, idx_w;
    logic [SEL_W-1:0] sel_w;
    logic             cap_w;
    ring_state_e      state_w;

    ring_regs #(.W(W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
        .wdata(reg_wdata), .raddr(reg_raddr), .cur_idx(idx_w),
        .state(state_w), .run(run_w), .start_addr(start_w),
        .last_idx(last_w), .tail_now(tail_w), .rdata(reg_rdata)
    );

    ring_fetch_ctrl #(.W(W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run_w), .start_addr(start_w),
        .last_idx(last_w), .tail_now(tail_w), .mem_ack(mem_ack),
        .desc_ready(desc_ready), .state(state_w), .cur_idx(idx_w),
        .word_sel(sel_w), .cap_en(cap_w), .mem_req(mem_req),
        .mem_addr(mem_addr), .desc_valid(desc_valid),
        .desc_addr(desc_addr), .susp_irq(susp_irq)
    );

    ring_desc_asm #(.W(W)) u_asm (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_w), .word_sel(sel_w),
        .rdata(mem_rdata), .desc_word(desc_word)
    );
endmodule

// File: rtl/desc_ring_fetch_chk.sv
// Protocol checks on the ring fetcher's ports and state, bound to the top.
module desc_ring_fetch_chk
    import desc_ring_pkg::*;
#(
    parameter int W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run,
    input ring_state_e             state,
    input logic                    mem_req,
    input logic                    mem_ack,
    input logic [W-1:0]            mem_addr,
    input logic                    desc_valid,
    input logic                    desc_ready,
    input logic [DESC_WORDS*W-1:0] desc_word,
    input logic                    susp_irq
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && run) |=> (mem_req && $stable(mem_addr)));

    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R4
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready && run) |=> (desc_valid && $stable(desc_word)));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && desc_valid));

    // R9
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!mem_req && !desc_valid));

    // R10
    irq_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_irq |-> (state == ST_SUSP));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_irq |=> !susp_irq);
endmodule

bind desc_ring_fetch desc_ring_fetch_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_w), .state(state_w),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_word(desc_word), .susp_irq(susp_irq)
);

// File: tb/desc_ring_fetch_test.sv
`timescale 1ns/1ps
module desc_ring_fetch_test;
    localparam int W     = 32;
    localparam int IDX_W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_waddr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [2:0]   reg_raddr = '0;
    logic [31:0]  reg_rdata;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_ack = 1'b0;
    logic [31:0]  mem_rdata;
    logic         desc_valid;
    logic         desc_ready = 1'b0;
    logic [127:0] desc_word;
    logic [31:0]  desc_addr;
    logic         susp_irq;

    int errors = 0;
    int checks = 0;
    int ack_mode = 0;    // 0 always, 1 random
    int ready_mode = 0;  // 0 always, 1 random, 2 held low
    bit comp_en = 1'b0;
    int irq_count = 0;
    logic [31:0] acc_q[$];

    // reference model state
    int          m_state = 0, m_cur = 0, m_w = 0, m_run = 0, m_last = 0, m_tail = 0;
    logic [31:0] m_start = '0;
    bit          m_irq = 1'b0;

    always #2.5 clk = ~clk;

    desc_ring_fetch #(.W(W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_word(desc_word), .desc_addr(desc_addr), .susp_irq(susp_irq)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    assign mem_rdata = memf(mem_addr);

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advances on each clock from the bench-driven inputs
    always @(posedge clk) begin
        int te, ns, nc;
        if (!rst_n) begin
            m_state = 0; m_cur = 0; m_w = 0; m_run = 0; m_last = 0; m_tail = 0;
            m_start = '0; m_irq = 1'b0;
        end else begin
            te = (reg_we && reg_waddr == 3'd3) ? int'(reg_wdata[IDX_W-1:0]) : m_tail;
            ns = m_state;
            if (m_run == 0) begin
                ns = 0; m_cur = 0; m_w = 0;
            end else begin
                case (m_state)
                    0: begin m_w = 0; ns = (te != m_cur) ? 1 : 3; end
                    1: if (mem_ack) begin
                           if (m_w == 3) ns = 2;
                           m_w = (m_w + 1) % 4;
                       end
                    2: if (desc_ready) begin
                           nc = (m_cur == m_last) ? 0 : m_cur + 1;
                           m_cur = nc;
                           ns = (te != nc) ? 1 : 3;
                       end
                    default: if (te != m_cur) ns = 1;
                endcase
            end
            m_irq = (m_run != 0) && ns == 3 && m_state != 3;
            m_state = ns;
            if (reg_we) begin
                case (reg_waddr)
                    3'd0: m_run = int'(reg_wdata[0]);
                    3'd1: m_start = {reg_wdata[31:4], 4'b0000};
                    3'd2: m_last = int'(reg_wdata[IDX_W-1:0]);
                    3'd3: m_tail = int'(reg_wdata[IDX_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    // Handshake inputs and read address, driven just after each rising edge
    always @(posedge clk) begin
        #1;
        mem_ack    <= (ack_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
        desc_ready <= (ready_mode == 0) ? 1'b1 :
                      (ready_mode == 1) ? ($urandom % 2 == 0) : 1'b0;
        reg_raddr  <= reg_raddr + 3'd1;
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        logic [31:0] a, er;
        #1;
        if (comp_en) begin
            a = m_start + 32'(m_cur) * 32'd16;
            check(mem_req == (m_state == 1), "R3 mem_req", 128'(mem_req), 128'(m_state == 1));
            if (m_state == 1)
                check(mem_addr == a + 32'(m_w) * 4, "R3 mem_addr", 128'(mem_addr),
                      128'(a + 32'(m_w) * 4));
            check(desc_valid == (m_state == 2), "R4 desc_valid", 128'(desc_valid),
                  128'(m_state == 2));
            if (m_state == 2) begin
                check(desc_addr == a, "R4 desc_addr", 128'(desc_addr), 128'(a));
                check(desc_word == {memf(a + 12), memf(a + 8), memf(a + 4), memf(a)},
                      "R4 desc_word", desc_word,
                      {memf(a + 12), memf(a + 8), memf(a + 4), memf(a)});
            end
            check(susp_irq == m_irq, "R10 susp_irq", 128'(susp_irq), 128'(m_irq));
            case (reg_raddr)
                3'd0: er = 32'(m_run);
                3'd1: er = m_start;
                3'd2: er = 32'(m_last);
                3'd3: er = 32'(m_tail);
                3'd4: er = a;
                3'd5: er = 32'(m_state);
                default: er = '0;
            endcase
            check(reg_rdata == er, "R2/R11 reg_rdata", 128'(reg_rdata), 128'(er));
            if (desc_valid && desc_ready) acc_q.push_back(desc_addr);
            if (susp_irq) irq_count++;
        end
    end

    task automatic wr(input logic [2:0] ad, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = ad; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_state(input int s);
        for (int i = 0; i < 400 && m_state != s; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ic;
        idle(4);
        comp_en = 1'b1;
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R1: stopped and quiet after reset
        check(!mem_req && !desc_valid && !susp_irq, "R1 reset outputs",
              {mem_req, desc_valid, susp_irq}, 0);

        wr(3'd1, 32'h0000_100F);      // start address, low bits dropped
        wr(3'd2, 32'd3);              // four slots
        wr(3'd4, 32'hDEAD_BEEF);      // read-only, ignored (R2)
        ic = irq_count;
        wr(3'd0, 32'd1);              // run with tail == current
        idle(3);
        // R5: suspends at once when tail equals current
        check(irq_count == ic + 1, "R5 empty-start suspend", irq_count, ic + 1);

        ack_mode = 1;
        wr(3'd3, 32'd2);
        // R7: suspended engine restarts on a tail write
        check(mem_req, "R7 restart fetch", mem_req, 1);
        wait_state(3);
        wr(3'd3, 32'd1);              // slots 2, 3 then wrap to 0
        wait_state(3); idle(2);
        // R6: wrap after the last slot
        check(acc_q.size() == 5, "R6 accepted count", acc_q.size(), 5);
        if (acc_q.size() == 5) begin
            check(acc_q[2] == 32'h1020 && acc_q[3] == 32'h1030 && acc_q[4] == 32'h1000,
                  "R6 wrap order", {acc_q[2], acc_q[3], acc_q[4]},
                  {32'h1020, 32'h1030, 32'h1000});
        end

        ready_mode = 1;               // back-pressure
        wr(3'd3, 32'd0);
        wait_state(3);

        // R8: tail write in the same cycle as the accept of the last owned slot
        ready_mode = 2;
        wr(3'd3, 32'd1);              // slot 0 owned
        wait_state(2);
        ready_mode = 0;               // ready rises at the next edge
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = 3'd3; reg_wdata = 32'd3;
        ic = irq_count;
        @(negedge clk);
        reg_we = 1'b0;
        #2;
        check(mem_req && irq_count == ic, "R8 same-cycle tail", {mem_req, irq_count},
              {1'b1, ic});
        wait_state(3);

        // R9: stop in the middle of a fetch
        ack_mode = 1; ready_mode = 0;
        wr(3'd3, 32'd2);
        idle(1);
        wr(3'd0, 32'd0);
        idle(1); #2;
        check(!mem_req && !desc_valid, "R9 stop quiet", {mem_req, desc_valid}, 0);
        wr(3'd3, 32'd0);
        idle(3); #2;
        check(!mem_req && !desc_valid, "R9 tail while stopped", {mem_req, desc_valid}, 0);
        wr(3'd0, 32'd1);              // restart from slot 0 with tail 0: suspend
        wait_state(3);
        wr(3'd3, 32'd2);
        wait_state(3);
        idle(4);

        // R11: covered by the per-cycle status reads
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule